// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the sequencer of a multi-cycle processor datapath. It owns a 4-bit state register and steps each instruction through a series of one-cycle phases on a shared memory and a single ALU. Every instruction begins with an instruction-fetch phase and a register-read/decode phase. After decode, the machine follows one of five instruction-class paths: register-register arithmetic, OR with an immediate, load word, store word, and branch-on-equal. Each path has its own execute, memory and write-back states as the class needs. At the end of a path the machine returns to fetch.

It is a Moore machine. Every datapath select, every write enable and the 2-bit ALU operation code depend only on the current state. They are produced from registers, so no combinational path runs from the opcode or the Zero flag to any output. The opcode is examined only in the decode state. The Zero flag is examined only in the branch-compare state. A register-register, OR-immediate or store instruction takes four cycles, a load takes five, and a branch takes three when the operands differ or four when it is taken. An opcode outside the five supported ones returns the machine to fetch directly after decode.

Top module: `mcc_fsm`

## Requirements
- R1: A synchronous reset sampled high at a clock edge puts the machine in fetch from that edge. This holds in every state, including decode and branch-compare, where reset wins over the dispatch the inputs would otherwise cause.
- R2: In fetch, pc_wr=1, ir_wr=1, iord=0 (address from PC), alu_sel_a=0 (PC), alu_sel_b=00 (constant 4), alu_op=00 (add), pc_src=0, and every other output is 0. Fetch is always followed by decode, where every output is 0.
- R3: Opcode 000000 (register-register) runs through two states after decode. The execute state has alu_sel_a=1, alu_sel_b=01 (register B) and alu_op=10 (use function field). The write-back state has reg_wr=1, reg_dst=1 (rd) and mem_to_reg=0. The machine then returns to fetch, for four cycles in total.
- R4: Opcode 001101 (OR immediate) runs through two states after decode. The execute state has alu_sel_a=1, alu_sel_b=11 (extended immediate), ext_sign=0 (zero extension) and alu_op=11 (OR). The write-back state has reg_wr=1, reg_dst=0 (rt) and mem_to_reg=0. The instruction takes four cycles.
- R5: Opcode 100011 (load) runs through three states after decode. The address state has alu_sel_a=1, alu_sel_b=11, ext_sign=1 and alu_op=00. The memory state has only iord=1. The write-back state has reg_wr=1, reg_dst=0 and mem_to_reg=1. The instruction takes five cycles.
- R6: Opcode 101011 (store) runs through two states after decode. The address state has the same outputs as the load address state. The memory state has mem_wr=1 and iord=1. The instruction takes four cycles.
- R7: For opcode 000100 (branch-on-equal), the compare state has alu_sel_a=1, alu_sel_b=01 and alu_op=01 (subtract). If zero=1 in the compare state, a target state follows with pc_wr_cond=1, pc_src=1, alu_sel_a=0, alu_sel_b=10 (shifted immediate), ext_sign=1 and alu_op=00, and the branch takes four cycles.
- R8: For branch-on-equal with zero=0 in the compare state, the machine goes straight back to fetch, so the branch takes three cycles.
- R9: Any opcode other than the five listed sends decode straight back to fetch, with no write enable asserted in between.
- R10: The opcode input has no effect outside decode, and zero has no effect outside branch-compare. At most one of ir_wr, mem_wr, reg_wr and pc_wr_cond is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write gated by the zero flag in the datapath |
| pc_src | output | 1 | PC source: 0 ALU result, 1 branch target |
| ir_wr | output | 1 | Instruction register write |
| iord | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_wr | output | 1 | Memory write |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write-back data: 0 ALU output register, 1 memory data |
| alu_sel_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_sel_b | output | 2 | ALU operand B: 00 four, 01 register B, 10 shifted immediate, 11 immediate |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |

## Verification
Two events can meet in one cycle. The synchronous reset can be asserted in the same cycle that a dispatch decision is due. That happens in decode with a valid opcode present, and in branch-compare with zero=1. The bench raises reset in exactly those cycles and also in the middle of a load. The reference model predicts fetch outputs for the cycle that follows, which shows whether reset won or the path went on. During all other instructions, the bench drives random values on opcode and zero outside the cycles in which they count, so any leak of these inputs into the sequence shows up in the cycle-by-cycle comparison.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'b0000,
        ST_DECODE  = 4'b0001,
        ST_BR_CMP  = 4'b0010,
        ST_BR_TAKE = 4'b0011,
        ST_R_EXE   = 4'b0100,
        ST_R_WB    = 4'b0101,
        ST_ORI_EXE = 4'b0110,
        ST_ORI_WB  = 4'b0111,
        ST_LW_ADR  = 4'b1000,
        ST_LW_MEM  = 4'b1001,
        ST_LW_WB   = 4'b1010,
        ST_SW_ADR  = 4'b1011,
        ST_SW_MEM  = 4'b1100
    } state_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_OR   = 2'b11
    } aluop_e;

    typedef enum logic [1:0] {
        SELB_FOUR = 2'b00,
        SELB_REGB = 2'b01,
        SELB_SHIM = 2'b10,
        SELB_IMM  = 2'b11
    } selb_e;

    typedef enum logic [2:0] {
        CLS_R   = 3'd0,
        CLS_ORI = 3'd1,
        CLS_LW  = 3'd2,
        CLS_SW  = 3'd3,
        CLS_BEQ = 3'd4,
        CLS_BAD = 3'd5
    } iclass_e;

    typedef struct packed {
        logic   pc_wr;
        logic   pc_wr_cond;
        logic   pc_src;
        logic   ir_wr;
        logic   iord;
        logic   mem_wr;
        logic   reg_wr;
        logic   reg_dst;
        logic   mem_to_reg;
        logic   alu_sel_a;
        selb_e  alu_sel_b;
        aluop_e alu_op;
        logic   ext_sign;
    } ctrl_t;

    typedef struct packed {
        state_e state;
        ctrl_t  ctrl;
    } fsm_t;

endpackage

// File: rtl/mcc_opdec.sv
module mcc_opdec
    import mcc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          iclass
);
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: iclass = CLS_R;
            OPC_ORI:   iclass = CLS_ORI;
            OPC_LW:    iclass = CLS_LW;
            OPC_SW:    iclass = CLS_SW;
            OPC_BEQ:   iclass = CLS_BEQ;
            default:   iclass = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_e  cur,
    input  iclass_e iclass,
    input  logic    zero,
    output state_e  nxt
);
    state_e dispatch;

    always_comb begin
        unique case (iclass)
            CLS_R:   dispatch = ST_R_EXE;
            CLS_ORI: dispatch = ST_ORI_EXE;
            CLS_LW:  dispatch = ST_LW_ADR;
            CLS_SW:  dispatch = ST_SW_ADR;
            CLS_BEQ: dispatch = ST_BR_CMP;
            default: dispatch = ST_FETCH;
        endcase
    end

    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE:  nxt = dispatch;
            ST_BR_CMP:  nxt = zero ? ST_BR_TAKE : ST_FETCH;
            ST_BR_TAKE: nxt = ST_FETCH;
            ST_R_EXE:   nxt = ST_R_WB;
            ST_R_WB:    nxt = ST_FETCH;
            ST_ORI_EXE: nxt = ST_ORI_WB;
            ST_ORI_WB:  nxt = ST_FETCH;
            ST_LW_ADR:  nxt = ST_LW_MEM;
            ST_LW_MEM:  nxt = ST_LW_WB;
            ST_LW_WB:   nxt = ST_FETCH;
            ST_SW_ADR:  nxt = ST_SW_MEM;
            ST_SW_MEM:  nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_rom.sv
module mcc_ctrl_rom
    import mcc_pkg::*;
(
    input  state_e st,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl = '0;
        case (st)
            ST_FETCH: begin
                ctrl.pc_wr     = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.alu_sel_b = SELB_FOUR;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_BR_CMP: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SELB_REGB;
                ctrl.alu_op    = ALU_SUB;
            end
            ST_BR_TAKE: begin
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = 1'b1;
                ctrl.alu_sel_b  = SELB_SHIM;
                ctrl.alu_op     = ALU_ADD;
                ctrl.ext_sign   = 1'b1;
            end
            ST_R_EXE: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SELB_REGB;
                ctrl.alu_op    = ALU_FUNC;
            end
            ST_R_WB: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.reg_dst = 1'b1;
            end
            ST_ORI_EXE: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SELB_IMM;
                ctrl.alu_op    = ALU_OR;
            end
            ST_ORI_WB: begin
                ctrl.reg_wr = 1'b1;
            end
            ST_LW_ADR, ST_SW_ADR: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SELB_IMM;
                ctrl.alu_op    = ALU_ADD;
                ctrl.ext_sign  = 1'b1;
            end
            ST_LW_MEM: begin
                ctrl.iord = 1'b1;
            end
            ST_LW_WB: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            ST_SW_MEM: begin
                ctrl.iord   = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/mcc_fsm.sv
module mcc_fsm
    import mcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             zero,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_src,
    output logic             ir_wr,
    output logic             iord,
    output logic             mem_wr,
    output logic             reg_wr,
    output logic             reg_dst,
    output logic             mem_to_reg,
    output logic             alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic [1:0]       alu_op,
    output logic             ext_sign
);
    fsm_t    fsm_d, fsm_q;
    iclass_e iclass;
    state_e  state_nxt;
    ctrl_t   ctrl_nxt;
    ctrl_t   ctrl_rst;

    mcc_opdec u_opdec (
        .opcode (opcode),
        .iclass (iclass)
    );

    mcc_next_state u_next (
        .cur    (fsm_q.state),
        .iclass (iclass),
        .zero   (zero),
        .nxt    (state_nxt)
    );

    mcc_ctrl_rom u_rom_next (
        .st   (state_nxt),
        .ctrl (ctrl_nxt)
    );

    mcc_ctrl_rom u_rom_rst (
        .st   (ST_FETCH),
        .ctrl (ctrl_rst)
    );

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.state = state_nxt;
        fsm_d.ctrl  = ctrl_nxt;
        if (rst) begin
            fsm_d.state = ST_FETCH;
            fsm_d.ctrl  = ctrl_rst;
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign pc_wr      = fsm_q.ctrl.pc_wr;
    assign pc_wr_cond = fsm_q.ctrl.pc_wr_cond;
    assign pc_src     = fsm_q.ctrl.pc_src;
    assign ir_wr      = fsm_q.ctrl.ir_wr;
    assign iord       = fsm_q.ctrl.iord;
    assign mem_wr     = fsm_q.ctrl.mem_wr;
    assign reg_wr     = fsm_q.ctrl.reg_wr;
    assign reg_dst    = fsm_q.ctrl.reg_dst;
    assign mem_to_reg = fsm_q.ctrl.mem_to_reg;
    assign alu_sel_a  = fsm_q.ctrl.alu_sel_a;
    assign alu_sel_b  = fsm_q.ctrl.alu_sel_b;
    assign alu_op     = fsm_q.ctrl.alu_op;
    assign ext_sign   = fsm_q.ctrl.ext_sign;
endmodule

// File: rtl/mcc_fsm_chk.sv
module mcc_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_src,
    input logic       ir_wr,
    input logic       iord,
    input logic       mem_wr,
    input logic       reg_wr,
    input logic       reg_dst,
    input logic       mem_to_reg,
    input logic [1:0] alu_op
);
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> (ir_wr && pc_wr));

    assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> !(ir_wr || pc_wr || pc_wr_cond || mem_wr || reg_wr));

    assert_rtype_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_dst) |-> ($past(alu_op) == 2'b10));

    assert_ori_wb_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_dst && !mem_to_reg) |-> ($past(alu_op) == 2'b11));

    assert_load_wb_R5: assert property (@(posedge clk) disable iff (rst)
        mem_to_reg |-> (reg_wr && !reg_dst && $past(iord) && !$past(mem_wr)));

    assert_store_end_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    assert_branch_take_R7: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (pc_src && ($past(alu_op) == 2'b01)));

    assert_one_write_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_wr, mem_wr, reg_wr, pc_wr_cond}));
endmodule

bind mcc_fsm mcc_fsm_chk u_chk (.*);

// File: tb/test_mcc_fsm.sv
module test_mcc_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       zero = 1'b0;
    logic pc_wr, pc_wr_cond, pc_src, ir_wr, iord, mem_wr, reg_wr, reg_dst, mem_to_reg;
    logic alu_sel_a, ext_sign;
    logic [1:0] alu_sel_b, alu_op;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mcc_fsm i_mcc_fsm (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .ir_wr(ir_wr),
        .iord(iord), .mem_wr(mem_wr), .reg_wr(reg_wr), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
        .alu_op(alu_op), .ext_sign(ext_sign)
    );

    // Expected control word, packed as
    // {pc_wr,pc_wr_cond,pc_src,ir_wr,iord,mem_wr,reg_wr,reg_dst,mem_to_reg,sel_a,sel_b,alu_op,ext}
    function automatic logic [14:0] cw(input bit pw, input bit pc, input bit ps, input bit ir,
                                       input bit io, input bit mw, input bit rw, input bit rd,
                                       input bit mr, input bit sa, input bit [1:0] sb,
                                       input bit [1:0] op, input bit ex);
        return {pw, pc, ps, ir, io, mw, rw, rd, mr, sa, sb, op, ex};
    endfunction

    function automatic logic [14:0] observed();
        return {pc_wr, pc_wr_cond, pc_src, ir_wr, iord, mem_wr, reg_wr, reg_dst,
                mem_to_reg, alu_sel_a, alu_sel_b, alu_op, ext_sign};
    endfunction

    logic [14:0] W_FETCH, W_DEC, W_BCMP, W_BTAKE, W_REXE, W_RWB, W_OEXE, W_OWB;
    logic [14:0] W_ADR, W_LMEM, W_LWB, W_SMEM;

    initial begin
        W_FETCH = cw(1,0,0,1,0,0,0,0,0,0,2'b00,2'b00,0);
        W_DEC   = '0;
        W_BCMP  = cw(0,0,0,0,0,0,0,0,0,1,2'b01,2'b01,0);
        W_BTAKE = cw(0,1,1,0,0,0,0,0,0,0,2'b10,2'b00,1);
        W_REXE  = cw(0,0,0,0,0,0,0,0,0,1,2'b01,2'b10,0);
        W_RWB   = cw(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,0);
        W_OEXE  = cw(0,0,0,0,0,0,0,0,0,1,2'b11,2'b11,0);
        W_OWB   = cw(0,0,0,0,0,0,1,0,0,0,2'b00,2'b00,0);
        W_ADR   = cw(0,0,0,0,0,0,0,0,0,1,2'b11,2'b00,1);
        W_LMEM  = cw(0,0,0,0,1,0,0,0,0,0,2'b00,2'b00,0);
        W_LWB   = cw(0,0,0,0,0,0,1,0,1,0,2'b00,2'b00,0);
        W_SMEM  = cw(0,0,0,0,1,1,0,0,0,0,2'b00,2'b00,0);
    end

    task automatic check(input logic [14:0] exp, input string tag);
        logic [14:0] got;
        got = observed();
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
        end
    endtask

    // Reference model: expected words for one instruction, built from the requirements.
    logic [14:0] exp_q[$];
    string       tag_q[$];

    task automatic build(input logic [5:0] op, input bit z);
        exp_q.delete(); tag_q.delete();
        exp_q.push_back(W_FETCH); tag_q.push_back("R2");
        exp_q.push_back(W_DEC);   tag_q.push_back("R2");
        case (op)
            6'b000000: begin
                exp_q.push_back(W_REXE); tag_q.push_back("R3");
                exp_q.push_back(W_RWB);  tag_q.push_back("R3");
            end
            6'b001101: begin
                exp_q.push_back(W_OEXE); tag_q.push_back("R4");
                exp_q.push_back(W_OWB);  tag_q.push_back("R4");
            end
            6'b100011: begin
                exp_q.push_back(W_ADR);  tag_q.push_back("R5");
                exp_q.push_back(W_LMEM); tag_q.push_back("R5");
                exp_q.push_back(W_LWB);  tag_q.push_back("R5");
            end
            6'b101011: begin
                exp_q.push_back(W_ADR);  tag_q.push_back("R6");
                exp_q.push_back(W_SMEM); tag_q.push_back("R6");
            end
            6'b000100: begin
                exp_q.push_back(W_BCMP); tag_q.push_back(z ? "R7" : "R8");
                if (z) begin
                    exp_q.push_back(W_BTAKE); tag_q.push_back("R7");
                end
            end
            default: ;
        endcase
    endtask

    // Runs one instruction and checks every cycle. Opcode and zero carry junk
    // outside the cycles where they count (R10). rst_at >= 0 raises reset in that cycle.
    task automatic run_instr(input logic [5:0] op, input bit z, input int rst_at);
        build(op, z);
        for (int i = 0; i < exp_q.size(); i++) begin
            check(exp_q[i], (op inside {6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100})
                            ? tag_q[i] : ((i == 0) ? "R9" : (i == 1 ? "R9" : tag_q[i])));
            opcode = (i == 1) ? op : 6'($urandom);
            zero   = (i == 2 && op == 6'b000100) ? z : 1'($urandom);
            if (i == rst_at) begin
                rst = 1'b1;
                @(posedge clk); @(negedge clk);
                rst = 1'b0;
                check(W_FETCH, "R1");
                return;
            end
            @(posedge clk); @(negedge clk);
        end
        // R10/R9: nothing remains of the instruction; the next cycle is fetch.
        check(W_FETCH, (op inside {6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100})
                       ? "R10" : "R9");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        opcode = 6'b100011;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check(W_FETCH, "R1");
        end
        rst = 1'b0;

        run_instr(6'b000000, 1'b0, -1);   // R3
        run_instr(6'b001101, 1'b1, -1);   // R4
        run_instr(6'b100011, 1'b0, -1);   // R5
        run_instr(6'b101011, 1'b1, -1);   // R6
        run_instr(6'b000100, 1'b1, -1);   // R7 taken
        run_instr(6'b000100, 1'b0, -1);   // R8 not taken
        run_instr(6'b111111, 1'b1, -1);   // R9 unsupported
        run_instr(6'b000010, 1'b0, -1);   // R9 unsupported
        run_instr(6'b100011, 1'b0, 1);    // R1 reset in decode with valid opcode
        run_instr(6'b000100, 1'b1, 2);    // R1 reset in branch compare with zero=1
        run_instr(6'b100011, 1'b0, 3);    // R1 reset in load memory state
        for (int n = 0; n < 40; n++) begin
            logic [5:0] ops[6] = '{6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b010101};
            run_instr(ops[$urandom_range(0, 5)], 1'($urandom), -1);  // R10 mixed stream
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule